// File: doc/BRIEF.md
# Serial Command Frame to Memory Request Bridge

The bridge sits between a byte-wide serial receiver and a simple single-request memory port. The receiver side arrives as a byte value with a one-cycle valid strobe, and every incoming byte is pushed into an eight-byte sliding window. On the cycle after each arrival, the window is tested for a complete command frame. The two oldest bytes must both be 0xAA and the newest byte must be 0x55. A byte pair carries the 16-bit address, one byte is the opcode, and a second byte pair carries the 16-bit data.

When a frame is accepted, the bridge raises one memory request and holds it until the memory side reports completion. For a read, the bridge then hands the low byte of the returned word to a serial transmitter. It holds the send strobe until the transmitter acknowledges. Bytes that do not form a frame are simply shifted out of the window, so a stream that starts misaligned or is corrupted recovers as soon as a clean frame has passed through.

The controller has three states:
- `ST_IDLE` waits for a frame.
- `ST_MEM_WAIT` holds the memory request.
- `ST_TX_WAIT` holds the transmit strobe.

It has four transitions:
- IDLE→MEM_WAIT when a frame matches.
- MEM_WAIT→IDLE when a write completes.
- MEM_WAIT→TX_WAIT when a read completes.
- TX_WAIT→IDLE when the transmitter acknowledges.

Top module: `uart_frame_bridge`

## Requirements
- R1: While reset is asserted and right after it, `mem_req` and `tx_send` are 0.
- R2: The frame, oldest byte first, is 0xAA, 0xAA, address[15:8], address[7:0], opcode, data[15:8], data[7:0], 0x55. If the opcode is 0xA5, `mem_req` rises exactly two clock edges after the edge that takes in the trailer byte. At that point `mem_we`=1, `mem_bank`=address[15:14], `mem_addr`=address[13:0] and `mem_wdata`=data.
- R3: A frame with opcode 0x5A issues a request with `mem_we`=0 and the same bank and address split. The frame's data bytes have no effect.
- R4: `mem_req` stays high until the edge where `mem_done` is sampled high, and is low in the next cycle.
- R5: When a read completes, `tx_byte` takes `mem_rdata[7:0]` and `tx_send` is held high until `tx_done` is sampled. Exactly one byte goes out per read.
- R6: A write frame never raises `tx_send`.
- R7: A frame whose opcode is neither 0x5A nor 0xA5 produces no request.
- R8: A frame whose header or trailer byte differs produces no request. Stray bytes before a good frame do not prevent that frame from being accepted.
- R9: Frames that match while a request or a response byte is outstanding are dropped.
- R10: A match is tested only on the cycle after a byte arrives. An idle stream never re-issues the last frame.
- R11: `mem_we`, `mem_bank`, `mem_addr` and `mem_wdata` are stable while `mem_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_byte | input | 8 | Received byte |
| rx_valid | input | 1 | One-cycle strobe marking `rx_byte` valid |
| mem_req | output | 1 | Memory request, held until done |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_bank | output | 2 | Bank select, address[15:14] |
| mem_addr | output | 14 | Location within bank, address[13:0] |
| mem_wdata | output | 16 | Write data |
| mem_done | input | 1 | Memory completion strobe |
| mem_rdata | input | 16 | Read data, valid with `mem_done` |
| tx_byte | output | 8 | Byte to transmit |
| tx_send | output | 1 | Transmit request, held until `tx_done` |
| tx_done | input | 1 | Transmitter acknowledge |

## Verification
The assertions take for granted that `mem_done` is pulsed only while `mem_req` is high and that `tx_done` arrives only while `tx_send` is high. They also take for granted that `rx_valid` is a single-cycle strobe. The bench's memory and transmitter responders answer only after they see the matching request, and each drops its strobe one cycle later. The byte driver never holds `rx_valid` high for two edges in a row. The responder delays can be changed, so the bench can push whole extra frames into the window while a transaction is still open.

// File: rtl/ufb_pkg.sv
`timescale 1ns/1ps
package ufb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_MEM_WAIT = 2'd1,
        ST_TX_WAIT  = 2'd2
    } ufb_state_t;

    // byte slots inside the window, oldest = 0
    localparam int SLOT_HDR0  = 0;
    localparam int SLOT_HDR1  = 1;
    localparam int SLOT_ADR_H = 2;
    localparam int SLOT_ADR_L = 3;
    localparam int SLOT_OP    = 4;
    localparam int SLOT_DAT_H = 5;
    localparam int SLOT_DAT_L = 6;
    localparam int SLOT_TRL   = 7;
    localparam int FRAME_LEN  = 8;

endpackage

// File: rtl/ufb_window.sv
`timescale 1ns/1ps
module ufb_window #(
    parameter int BYTE_W = 8,
    parameter int DEPTH  = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [BYTE_W-1:0]             in_byte,
    input  logic                          in_valid,
    output logic [DEPTH-1:0][BYTE_W-1:0]  win,
    output logic                          fresh
);

    // newest byte enters at DEPTH-1, oldest sits at 0
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        if (i == DEPTH - 1) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)        win[i] <= '0;
                else if (in_valid) win[i] <= in_byte;
            end
        end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)        win[i] <= '0;
                else if (in_valid) win[i] <= win[i+1];
            end
        end
    end

    // one-cycle marker: window changed on the previous edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fresh <= 1'b0;
        else        fresh <= in_valid;
    end

endmodule

// File: rtl/ufb_parser.sv
`timescale 1ns/1ps
module ufb_parser
    import ufb_pkg::*;
#(
    parameter int               BYTE_W = 8,
    parameter logic [BYTE_W-1:0] HDR_V = 8'hAA,
    parameter logic [BYTE_W-1:0] TRL_V = 8'h55,
    parameter logic [BYTE_W-1:0] OP_RD = 8'h5A,
    parameter logic [BYTE_W-1:0] OP_WR = 8'hA5,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic [FRAME_LEN-1:0][BYTE_W-1:0] win,
    input  logic                             fresh,
    output logic                             hit,
    output logic                             is_write,
    output logic [WORD_W-1:0]                addr,
    output logic [WORD_W-1:0]                data
);

    logic hdr_ok;
    logic trl_ok;
    logic op_rd;
    logic op_wr;

    always_comb begin
        hdr_ok   = (win[SLOT_HDR0] == HDR_V) && (win[SLOT_HDR1] == HDR_V);
        trl_ok   = (win[SLOT_TRL] == TRL_V);
        op_rd    = (win[SLOT_OP] == OP_RD);
        op_wr    = (win[SLOT_OP] == OP_WR);
        hit      = fresh && hdr_ok && trl_ok && (op_rd || op_wr);
        is_write = op_wr;
        addr     = {win[SLOT_ADR_H], win[SLOT_ADR_L]};
        data     = {win[SLOT_DAT_H], win[SLOT_DAT_L]};
    end

endmodule

// File: rtl/ufb_ctrl_fsm.sv
`timescale 1ns/1ps
module ufb_ctrl_fsm
    import ufb_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int BANK_W = 2,
    localparam int WORD_W = 2 * BYTE_W,
    localparam int LOC_W  = WORD_W - BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic              hit_write,
    input  logic [WORD_W-1:0] hit_addr,
    input  logic [WORD_W-1:0] hit_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [BANK_W-1:0] mem_bank,
    output logic [LOC_W-1:0]  mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_done,
    input  logic [BYTE_W-1:0] rd_low,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              tx_send,
    input  logic              tx_done
);

    ufb_state_t state;
    ufb_state_t state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (hit)      state_nx = ST_MEM_WAIT;
            ST_MEM_WAIT: if (mem_done) state_nx = mem_we ? ST_IDLE : ST_TX_WAIT;
            ST_TX_WAIT:  if (tx_done)  state_nx = ST_IDLE;
            default:                   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // command and response registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_we    <= 1'b0;
            mem_bank  <= '0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            tx_byte   <= '0;
        end else begin
            if (state == ST_IDLE && hit) begin
                mem_we    <= hit_write;
                mem_bank  <= hit_addr[WORD_W-1 -: BANK_W];
                mem_addr  <= hit_addr[LOC_W-1:0];
                mem_wdata <= hit_data;
            end
            if (state == ST_MEM_WAIT && mem_done && !mem_we) begin
                tx_byte <= rd_low;
            end
        end
    end

    always_comb begin
        mem_req = (state == ST_MEM_WAIT);
        tx_send = (state == ST_TX_WAIT);
    end

endmodule

// File: rtl/uart_frame_bridge.sv
`timescale 1ns/1ps
module uart_frame_bridge
    import ufb_pkg::*;
#(
    parameter int                BYTE_W = 8,
    parameter int                BANK_W = 2,
    parameter logic [BYTE_W-1:0] HDR_V  = 8'hAA,
    parameter logic [BYTE_W-1:0] TRL_V  = 8'h55,
    parameter logic [BYTE_W-1:0] OP_RD  = 8'h5A,
    parameter logic [BYTE_W-1:0] OP_WR  = 8'hA5,
    localparam int WORD_W = 2 * BYTE_W,
    localparam int LOC_W  = WORD_W - BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_valid,
    output logic              mem_req,
    output logic              mem_we,
    output logic [BANK_W-1:0] mem_bank,
    output logic [LOC_W-1:0]  mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_done,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              tx_send,
    input  logic              tx_done
);

    logic [FRAME_LEN-1:0][BYTE_W-1:0] win;
    logic                             fresh;
    logic                             hit;
    logic                             hit_write;
    logic [WORD_W-1:0]                hit_addr;
    logic [WORD_W-1:0]                hit_data;
    logic                             rdata_hi_unused;

    assign rdata_hi_unused = ^mem_rdata[WORD_W-1:BYTE_W];

    ufb_window #(.BYTE_W(BYTE_W), .DEPTH(FRAME_LEN)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_byte  (rx_byte),
        .in_valid (rx_valid),
        .win      (win),
        .fresh    (fresh)
    );

    ufb_parser #(
        .BYTE_W(BYTE_W), .HDR_V(HDR_V), .TRL_V(TRL_V),
        .OP_RD(OP_RD), .OP_WR(OP_WR)
    ) u_parser (
        .win      (win),
        .fresh    (fresh),
        .hit      (hit),
        .is_write (hit_write),
        .addr     (hit_addr),
        .data     (hit_data)
    );

    ufb_ctrl_fsm #(.BYTE_W(BYTE_W), .BANK_W(BANK_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (hit),
        .hit_write (hit_write),
        .hit_addr  (hit_addr),
        .hit_data  (hit_data),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_bank  (mem_bank),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_done  (mem_done),
        .rd_low    (mem_rdata[BYTE_W-1:0]),
        .tx_byte   (tx_byte),
        .tx_send   (tx_send),
        .tx_done   (tx_done)
    );

endmodule

// File: rtl/ufb_checker.sv
`timescale 1ns/1ps
module ufb_checker #(
    parameter int BYTE_W = 8,
    parameter int BANK_W = 2,
    localparam int WORD_W = 2 * BYTE_W,
    localparam int LOC_W  = WORD_W - BANK_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_valid,
    input logic              mem_req,
    input logic              mem_we,
    input logic [BANK_W-1:0] mem_bank,
    input logic [LOC_W-1:0]  mem_addr,
    input logic [WORD_W-1:0] mem_wdata,
    input logic              mem_done,
    input logic [BYTE_W-1:0] tx_byte,
    input logic              tx_send,
    input logic              tx_done
);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) mem_req && !mem_done |=> mem_req); // R4
    AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n) mem_req && mem_done |=> !mem_req); // R4
    AST_REQ_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_req) |-> $past(rx_valid, 2)); // R2
    AST_CMD_STABLE: assert property (@(posedge clk) disable iff (!rst_n) mem_req && !mem_done |=> $stable(mem_we) && $stable(mem_bank) && $stable(mem_addr) && $stable(mem_wdata)); // R11
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n) tx_send && !tx_done |=> tx_send && $stable(tx_byte)); // R5
    AST_TX_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n) $rose(tx_send) |-> !mem_we); // R6
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n) !(mem_req && tx_send)); // R9

endmodule

bind uart_frame_bridge ufb_checker #(.BYTE_W(BYTE_W), .BANK_W(BANK_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_bank  (mem_bank),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_done  (mem_done),
    .tx_byte   (tx_byte),
    .tx_send   (tx_send),
    .tx_done   (tx_done)
);

// File: tb/uart_frame_bridge_bench.sv
`timescale 1ns/1ps
module uart_frame_bridge_bench;

    typedef struct packed {
        logic        we;
        logic [15:0] addr;
        logic [15:0] data;
    } exp_req_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_valid = 1'b0;
    logic        mem_req;
    logic        mem_we;
    logic [1:0]  mem_bank;
    logic [13:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_done = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic [7:0]  tx_byte;
    logic        tx_send;
    logic        tx_done = 1'b0;

    int checks = 0;
    int errors = 0;
    int req_seen = 0;
    int req_exp = 0;
    int tx_seen = 0;
    int tx_exp = 0;
    int mem_delay = 3;
    int tx_delay = 4;
    int cycles = 0;

    exp_req_t    req_q[$];
    logic [7:0]  tx_q[$];
    logic [15:0] bench_mem [logic [15:0]];
    logic [15:0] shadow    [logic [15:0]];
    localparam logic [15:0] BLANK = 16'hC0DE;

    always #5 clk = ~clk;

    uart_frame_bridge u_uart_frame_bridge (
        .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_valid(rx_valid),
        .mem_req(mem_req), .mem_we(mem_we), .mem_bank(mem_bank),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_done(mem_done),
        .mem_rdata(mem_rdata), .tx_byte(tx_byte), .tx_send(tx_send),
        .tx_done(tx_done)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        rx_byte  = b;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] h0, input logic [7:0] h1, input logic [15:0] a,
                              input logic [7:0] op, input logic [15:0] d, input logic [7:0] tr,
                              input int gap);
        logic [7:0] bytes [8];
        bytes = '{h0, h1, a[15:8], a[7:0], op, d[15:8], d[7:0], tr};
        for (int i = 0; i < 8; i++) begin
            if (i != 0) repeat (gap) @(negedge clk);
            send_byte(bytes[i]);
        end
    endtask

    // driver: push expectation, then send
    task automatic do_write(input logic [15:0] a, input logic [15:0] d, input int gap);
        req_q.push_back('{we: 1'b1, addr: a, data: d});
        req_exp++;
        shadow[a] = d;
        send_frame(8'hAA, 8'hAA, a, 8'hA5, d, 8'h55, gap);
    endtask

    task automatic do_read(input logic [15:0] a, input logic [15:0] junk, input int gap);
        logic [15:0] w;
        w = shadow.exists(a) ? shadow[a] : BLANK;
        req_q.push_back('{we: 1'b0, addr: a, data: 16'h0});
        req_exp++;
        tx_q.push_back(w[7:0]);
        tx_exp++;
        send_frame(8'hAA, 8'hAA, a, 8'h5A, junk, 8'h55, gap);
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
        while (mem_req || tx_send) @(negedge clk);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_counts(input string tag);
        check(req_seen == req_exp, tag, req_seen, req_exp);
        check(tx_seen == tx_exp, tag, tx_seen, tx_exp);
    endtask

    // memory responder
    int mem_cnt = 0;
    always @(negedge clk) begin
        if (mem_done) begin
            mem_done = 1'b0;
            mem_cnt  = 0;
        end else if (mem_req) begin
            if (mem_cnt >= mem_delay) begin
                if (mem_we) bench_mem[{mem_bank, mem_addr}] = mem_wdata;
                else mem_rdata = bench_mem.exists({mem_bank, mem_addr}) ? bench_mem[{mem_bank, mem_addr}] : BLANK;
                mem_done = 1'b1;
            end else mem_cnt++;
        end
    end

    // transmitter responder
    int tx_cnt = 0;
    always @(negedge clk) begin
        if (tx_done) begin
            tx_done = 1'b0;
            tx_cnt  = 0;
        end else if (tx_send) begin
            if (tx_cnt >= tx_delay) tx_done = 1'b1;
            else tx_cnt++;
        end
    end

    // monitor: compare on rising request and rising send
    logic prev_req = 1'b0;
    logic prev_tx  = 1'b0;
    always @(negedge clk) begin
        if (rst_n && mem_req && !prev_req) begin
            req_seen++;
            if (req_q.size() == 0) begin
                check(1'b0, "R9 R10 unexpected request", {mem_bank, mem_addr}, 32'h0);
            end else begin
                exp_req_t e;
                e = req_q.pop_front();
                check(mem_we == e.we, e.we ? "R2 mem_we" : "R3 mem_we", mem_we, e.we);
                check({mem_bank, mem_addr} == e.addr, e.we ? "R2 bank/addr" : "R3 bank/addr", {mem_bank, mem_addr}, e.addr);
                if (e.we) check(mem_wdata == e.data, "R2 wdata", mem_wdata, e.data);
            end
        end
        if (rst_n && tx_send && !prev_tx) begin
            tx_seen++;
            if (tx_q.size() == 0) begin
                check(1'b0, "R6 unexpected tx byte", tx_byte, 32'h0);
            end else begin
                logic [7:0] eb;
                eb = tx_q.pop_front();
                check(tx_byte == eb, "R5 tx_byte", tx_byte, eb);
            end
        end
        prev_req = mem_req;
        prev_tx  = tx_send;
    end

    // watchdog
    initial begin
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check(mem_req == 1'b0, "R1 mem_req in reset", mem_req, 0);
        check(tx_send == 1'b0, "R1 tx_send in reset", tx_send, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!mem_req && !tx_send, "R1 idle after reset", {mem_req, tx_send}, 0);

        // R2: write with exact latency and bank split
        do_write(16'hC123, 16'h1234, 0);
        check(mem_req == 1'b0, "R2 req one edge after trailer", mem_req, 0);
        @(negedge clk);
        check(mem_req == 1'b1, "R2 req two edges after trailer", mem_req, 1);
        settle(3);
        check_counts("R6 write gives no tx");

        // R3 / R5: read back, junk in data bytes
        do_read(16'hC123, 16'hFFEE, 1);
        settle(3);
        check_counts("R5 one byte per read");
        do_read(16'h4007, 16'h0000, 2);
        settle(3);

        // R4: long memory response, request held
        mem_delay = 12;
        do_write(16'h0002, 16'h5A5D, 0);
        repeat (5) @(negedge clk);
        check(mem_req == 1'b1, "R4 req held while not done", mem_req, 1);
        settle(3);
        check(mem_req == 1'b0, "R4 req low after done", mem_req, 0);

        // R7: unknown opcode
        send_frame(8'hAA, 8'hAA, 16'h0100, 8'h77, 16'h9999, 8'h55, 1);
        settle(5);
        check_counts("R7 unknown opcode ignored");

        // R8: bad trailer, bad header, then resync after stray bytes
        send_frame(8'hAA, 8'hAA, 16'h0200, 8'hA5, 16'h1111, 8'h56, 0);
        send_frame(8'hAB, 8'hAA, 16'h0300, 8'hA5, 16'h2222, 8'h55, 0);
        settle(5);
        check_counts("R8 corrupt frames ignored");
        send_byte(8'h13);
        send_byte(8'hAA);
        send_byte(8'h02);
        do_write(16'h8010, 16'hBEEF, 0);
        settle(3);
        do_read(16'h8010, 16'h3344, 0);
        settle(3);
        check_counts("R8 resync accepted");

        // R9: frames during an outstanding write and during a response
        mem_delay = 60;
        do_write(16'h1111, 16'hA1A1, 1);
        send_frame(8'hAA, 8'hAA, 16'h2222, 8'hA5, 16'hB2B2, 8'h55, 1);
        settle(3);
        check_counts("R9 frame during request dropped");
        mem_delay = 2;
        tx_delay  = 40;
        do_read(16'h1111, 16'h0, 0);
        send_frame(8'hAA, 8'hAA, 16'h3333, 8'h5A, 16'h0, 8'h55, 0);
        settle(3);
        check_counts("R9 frame during response dropped");
        tx_delay = 4;

        // R10: idle window never re-issues
        repeat (50) @(negedge clk);
        check_counts("R10 no repeat on idle stream");
        check(req_q.size() == 0, "R10 queue drained", req_q.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule